// File: doc/BRIEF.md
# Programmable Bus Wait-State Generator

This block sets the length of each access on a small microcontroller bus. At the start of an access it looks at the target region, the chip-select index, the access direction, the bus mode and the timing configuration. From these it works out how many bus-clock cycles the access lasts. It then runs the access through those cycles. It flags the first cycle and every stretched cycle, and it raises a done strobe in the final cycle.

Accesses to external chip-select areas can also be held by an external ready input. While ready is low, the final cycle repeats.

The configuration bits arrive as plain inputs from registers held elsewhere. The block samples them only at the start of an access. Any change made while an access is in progress applies from the next access onward.

Top module: `wait_state_gen`

## Requirements
- R1: A register-region access (region code 2'b00) lasts 2 cycles when `reg_slow_i` is 0 and 3 cycles when it is 1.
- R2: An internal-memory access (region code 2'b01) lasts 1 cycle when `int_wait_i` is 0 and 2 cycles when it is 1.
- R3: An external access (region code 2'b10 or 2'b11) on the separate bus (`mux_mode_i`=0) whose chip-select no-wait bit (`cs_nowait_i[cs]`) is 1 lasts 1 cycle for a read (`we_i`=0) and 2 cycles for a write.
- R4: An external access on the separate bus with the no-wait bit at 0 uses the chip-select's wait code, `cs_code_i[2*cs+1:2*cs]`. Code 00 gives 2 cycles, 01 gives 3 cycles and 10 gives 4 cycles.
- R5: Wait code 11 is reserved and times like code 10 (4 cycles).
- R6: On the multiplexed bus (`mux_mode_i`=1), the no-wait bit is ignored. Code 00 gives 3 cycles and any other code gives 4 cycles.
- R7: With every configuration input at zero, an internal access lasts 1 cycle and an external access lasts 2 cycles.
- R8: `ready_i` is honoured for an external access whose no-wait bit is 0, and for every multiplexed access. For such an access, once the final cycle is reached it repeats, with `done_o` low, until `ready_i` is high.
- R9: For register-region, internal and no-wait external accesses, `ready_i` has no effect on the access length.
- R10: The region, index, direction, mode and configuration are sampled in the cycle a request is accepted. Changes made during the access do not alter its length.
- R11: `first_o` is high only in an access's first cycle. `busy_o` is high in every cycle of the access. `done_o` is high only in its last cycle. `wait_o` is high in every cycle after the first.
- R12: A request is accepted when the block is idle or in the cycle `done_o` is high, so accesses can run back to back. An accepted request starts its first cycle at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request |
| region_i | input | 2 | Region: 00 registers, 01 internal memory, 1x external |
| cs_idx_i | input | 2 | Chip-select index for external accesses |
| we_i | input | 1 | 1 for write, 0 for read |
| mux_mode_i | input | 1 | 1 selects the multiplexed external bus |
| reg_slow_i | input | 1 | Register-region extra cycle enable |
| int_wait_i | input | 1 | Internal-memory wait enable |
| cs_nowait_i | input | 4 | Per chip-select no-wait bit |
| cs_code_i | input | 8 | Per chip-select two-bit wait code |
| ready_i | input | 1 | External ready |
| busy_o | output | 1 | Access in progress |
| first_o | output | 1 | First cycle of an access |
| wait_o | output | 1 | Stretched (non-first) cycle |
| done_o | output | 1 | Last cycle of an access |

## Verification
On every cycle, the assertions check three properties of the sequencer. `done_o` appears only inside an access. A latched length stays fixed until the access ends. A ready stall keeps the sequencer parked on its final cycle.

The assertions also check that each accepted request opens with `first_o`, and that the computed length stays between one and four cycles.

The exact cycle counts depend on the region, the code, the mode and the direction, so only the bench's directed accesses can show them. The same holds for the cases where ready has no effect, for mid-access configuration changes, and for back-to-back starts.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
  localparam int unsigned MAX_LEN = 4;
  localparam int unsigned LEN_W   = $clog2(MAX_LEN + 1);

  typedef logic [LEN_W-1:0] len_t;

  typedef enum logic [1:0] {
    RGN_REG = 2'b00,
    RGN_INT = 2'b01,
    RGN_EXT = 2'b10,
    RGN_EXT_ALT = 2'b11
  } region_e;
endpackage

// File: rtl/wsg_len_calc.sv
module wsg_len_calc
  import wsg_pkg::*;
#(
  parameter int unsigned NUM_CS = 4,
  localparam int unsigned CS_W = $clog2(NUM_CS)
) (
  input  logic [1:0]          region_i,
  input  logic [CS_W-1:0]     cs_idx_i,
  input  logic                we_i,
  input  logic                mux_mode_i,
  input  logic                reg_slow_i,
  input  logic                int_wait_i,
  input  logic [NUM_CS-1:0]   cs_nowait_i,
  input  logic [2*NUM_CS-1:0] cs_code_i,
  output len_t                len_o,
  output logic                rdy_en_o
);
  logic [1:0] code;
  logic       nowait;

  assign code   = cs_code_i[2*cs_idx_i +: 2];
  assign nowait = cs_nowait_i[cs_idx_i];

  always_comb begin
    len_o    = len_t'(1);
    rdy_en_o = 1'b0;
    unique case (region_i)
      RGN_REG: len_o = reg_slow_i ? len_t'(3) : len_t'(2);
      RGN_INT: len_o = int_wait_i ? len_t'(2) : len_t'(1);
      default: begin
        if (mux_mode_i) begin
          // multiplexed bus always waits; no-wait bit is meaningless here
          rdy_en_o = 1'b1;
          len_o    = (code == 2'b00) ? len_t'(3) : len_t'(4);
        end else if (nowait) begin
          len_o = we_i ? len_t'(2) : len_t'(1);
        end else begin
          rdy_en_o = 1'b1;
          unique case (code)
            2'b00:   len_o = len_t'(2);
            2'b01:   len_o = len_t'(3);
            default: len_o = len_t'(4); // 11 reserved, times as 10
          endcase
        end
      end
    endcase
  end
endmodule

// File: rtl/wsg_seq.sv
module wsg_seq
  import wsg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  len_t len_i,
  input  logic rdy_en_i,
  input  logic ready_i,
  output logic busy_o,
  output logic first_o,
  output logic wait_o,
  output logic done_o
);
  logic busy_q, rdy_en_q;
  len_t cnt_q, len_q;
  logic start, last;

  assign last    = busy_q && (cnt_q == len_q);
  assign done_o  = last && (!rdy_en_q || ready_i);
  assign start   = req_i && (!busy_q || done_o);
  assign busy_o  = busy_q;
  assign first_o = busy_q && (cnt_q == len_t'(1));
  assign wait_o  = busy_q && (cnt_q != len_t'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      rdy_en_q <= 1'b0;
      cnt_q    <= '0;
      len_q    <= '0;
    end else if (start) begin
      busy_q   <= 1'b1;
      rdy_en_q <= rdy_en_i;
      cnt_q    <= len_t'(1);
      len_q    <= len_i;
    end else if (busy_q) begin
      if (done_o)     busy_q <= 1'b0;
      else if (!last) cnt_q  <= cnt_q + len_t'(1);
    end
  end

  a_r11_done_in_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  a_r12_start_opens_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> first_o);
  a_r10_len_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done_o) |=> $stable(len_q) && busy_q);
  a_r8_stall_parks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && !done_o) |=> last && $stable(cnt_q));
  a_r4_len_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |-> (len_i >= len_t'(1) && len_i <= len_t'(MAX_LEN)));
endmodule

// File: rtl/wait_state_gen.sv
module wait_state_gen
  import wsg_pkg::*;
#(
  parameter int unsigned NUM_CS = 4,
  localparam int unsigned CS_W = $clog2(NUM_CS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic [1:0]          region_i,
  input  logic [CS_W-1:0]     cs_idx_i,
  input  logic                we_i,
  input  logic                mux_mode_i,
  input  logic                reg_slow_i,
  input  logic                int_wait_i,
  input  logic [NUM_CS-1:0]   cs_nowait_i,
  input  logic [2*NUM_CS-1:0] cs_code_i,
  input  logic                ready_i,
  output logic                busy_o,
  output logic                first_o,
  output logic                wait_o,
  output logic                done_o
);
  len_t len;
  logic rdy_en;

  wsg_len_calc #(.NUM_CS(NUM_CS)) i_len (
    .region_i    (region_i),
    .cs_idx_i    (cs_idx_i),
    .we_i        (we_i),
    .mux_mode_i  (mux_mode_i),
    .reg_slow_i  (reg_slow_i),
    .int_wait_i  (int_wait_i),
    .cs_nowait_i (cs_nowait_i),
    .cs_code_i   (cs_code_i),
    .len_o       (len),
    .rdy_en_o    (rdy_en)
  );

  wsg_seq i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .len_i    (len),
    .rdy_en_i (rdy_en),
    .ready_i  (ready_i),
    .busy_o   (busy_o),
    .first_o  (first_o),
    .wait_o   (wait_o),
    .done_o   (done_o)
  );
endmodule

// File: tb/test_wait_state_gen.sv
module test_wait_state_gen;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, mux = 1'b0, reg_slow = 1'b0, int_wait = 1'b0, ready = 1'b1;
  logic [1:0] region = 2'b00, cs = 2'b00;
  logic [3:0] cs_nowait = '0;
  logic [7:0] cs_code = '0;
  logic busy, first, waitc, done;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wait_state_gen i_wait_state_gen (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .region_i(region), .cs_idx_i(cs),
    .we_i(we), .mux_mode_i(mux), .reg_slow_i(reg_slow), .int_wait_i(int_wait),
    .cs_nowait_i(cs_nowait), .cs_code_i(cs_code), .ready_i(ready),
    .busy_o(busy), .first_o(first), .wait_o(waitc), .done_o(done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // rel_at: cycle in which ready goes high (0 = high throughout, 99 = never)
  task automatic access(input logic [1:0] rg, input logic [1:0] c, input logic w,
                        input int exp, input int rel_at, input string tag);
    int n;
    bit strobe_ok;
    @(negedge clk);
    ready = (rel_at == 0);
    region = rg; cs = c; we = w; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    n = 1;
    strobe_ok = 1'b1;
    forever begin
      if (rel_at != 0 && n >= rel_at) ready = 1'b1;
      #1;
      if (!busy || first != (n == 1) || waitc != (n != 1)) strobe_ok = 1'b0;
      if (done || n >= 40) break;
      @(negedge clk);
      n++;
    end
    check(n == exp, tag, n, exp);
    check(strobe_ok, {tag, " R11 strobes"}, strobe_ok, 1);
    ready = 1'b1;
    @(negedge clk);
    #1;
    check(!busy && !done, {tag, " R11 idle after"}, busy, 0);
  endtask

  task automatic t_reset;
    #1;
    check(!busy && !first && !done && !waitc, "R11 reset idle", busy, 0);
  endtask

  task automatic t_defaults;
    access(2'b01, 2'd0, 1'b0, 1, 0, "R7 internal default");
    access(2'b10, 2'd3, 1'b1, 2, 0, "R7 external default");
  endtask

  task automatic t_reg_int;
    access(2'b00, 2'd0, 1'b0, 2, 0, "R1 reg fast");
    reg_slow = 1'b1;
    access(2'b00, 2'd0, 1'b1, 3, 0, "R1 reg slow");
    reg_slow = 1'b0;
    int_wait = 1'b1;
    access(2'b01, 2'd0, 1'b0, 2, 0, "R2 internal wait");
    int_wait = 1'b0;
  endtask

  task automatic t_separate;
    cs_nowait = 4'b0100;
    access(2'b10, 2'd2, 1'b0, 1, 0, "R3 nowait read");
    access(2'b11, 2'd2, 1'b1, 2, 0, "R3 nowait write");
    cs_nowait = '0;
    cs_code = 8'b11_10_01_00;
    access(2'b10, 2'd0, 1'b0, 2, 0, "R4 code00");
    access(2'b10, 2'd1, 1'b0, 3, 0, "R4 code01");
    access(2'b10, 2'd2, 1'b1, 4, 0, "R4 code10");
    access(2'b10, 2'd3, 1'b0, 4, 0, "R5 code11");
  endtask

  task automatic t_mux;
    mux = 1'b1;
    cs_nowait = 4'b1111;
    access(2'b10, 2'd0, 1'b0, 3, 0, "R6 mux code00");
    access(2'b10, 2'd1, 1'b1, 4, 0, "R6 mux code01");
    cs_nowait = '0;
    mux = 1'b0;
  endtask

  task automatic t_ready;
    access(2'b10, 2'd1, 1'b0, 6, 6, "R8 stall code01");
    mux = 1'b1;
    access(2'b10, 2'd0, 1'b0, 5, 5, "R8 stall mux");
    mux = 1'b0;
    access(2'b00, 2'd0, 1'b0, 2, 99, "R9 reg ignores ready");
    access(2'b01, 2'd0, 1'b0, 1, 99, "R9 internal ignores ready");
    cs_nowait = 4'b0010;
    access(2'b10, 2'd1, 1'b0, 1, 99, "R9 nowait ignores ready");
    cs_nowait = '0;
  endtask

  task automatic t_cfg_change;
    int n;
    cs_code = 8'b00;
    @(negedge clk);
    region = 2'b10; cs = 2'd0; we = 1'b0; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    cs_code = 8'b10; reg_slow = 1'b1; region = 2'b00;
    n = 1;
    forever begin
      #1;
      if (done || n >= 40) break;
      @(negedge clk);
      n++;
    end
    check(n == 2, "R10 midaccess change ignored", n, 2);
    reg_slow = 1'b0;
    access(2'b10, 2'd0, 1'b0, 4, 0, "R10 change applies next");
    cs_code = '0;
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    region = 2'b01; req = 1'b1;
    @(negedge clk);
    #1;
    check(first && done, "R12 first access done", done, 1);
    region = 2'b00;
    @(negedge clk);
    req = 1'b0;
    #1;
    check(busy && first && !done, "R12 second access started", first, 1);
    @(negedge clk);
    #1;
    check(done && waitc, "R12 second access done", done, 1);
    @(negedge clk);
  endtask

  initial begin
    t_reset;
    #(3*CLK_PERIOD);
    rst_n = 1'b1;
    t_defaults;
    t_reg_int;
    t_separate;
    t_mux;
    t_ready;
    t_cfg_change;
    t_back_to_back;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5000*CLK_PERIOD);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule